// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a single-port synchronous static memory of two-lane words, with each lane `LANE_W` bits wide (18-bit words by default). Address, select, write enable and lane enables are taken on the rising clock edge. A write hands over its data one cycle after its address. The pending write is parked in a one-entry buffer. The array is updated from that buffer only when the next write is accepted. Until then, reads that hit the buffered address are served from the buffer, merged lane by lane with the array word.

The data path is split into `din`, `dout` and `dout_en` instead of a shared bus. Two static mode pins choose how read data is presented. In flow-through mode the word appears in the cycle that follows the edge where the read was taken. In registered mode it appears one edge later. The output enable and sleep inputs switch the output off asynchronously.

The write buffer is a three-state machine:
- `BUF_EMPTY`: nothing is buffered. This is the reset state.
- `BUF_AWAIT`: a write address and lane mask are held, and the data is due on the next edge.
- `BUF_HELD`: address, mask and data are all held.

Transitions:
- EMPTY→AWAIT on an accepted write.
- AWAIT→AWAIT on a back-to-back write. The old entry commits with the data arriving on that edge.
- AWAIT→HELD on any other cycle.
- HELD→AWAIT on an accepted write, which also commits the held entry.
- HELD→HELD otherwise.
- EMPTY→EMPTY otherwise.

Top module: `lw_sram`

## Requirements
- R1: After reset `dout_en` is low, `dout` is zero, the buffer is empty and every array word reads as zero.
- R2: A cycle with `sel_n`=0 and `wr_n`=1 at a rising edge is a read of `addr`. It returns the current word at that address.
- R3: A cycle with `sel_n`=0 and `wr_n`=0 at edge n is a write of `addr`. Its data is taken from `din` at edge n+1.
- R4: `be_n[0]`=0 enables lane 0 (bits 8:0) and `be_n[1]`=0 enables lane 1 (bits 17:9). A write with `be_n`=2'b11 is an aborted write that changes no bit of any word.
- R5: An accepted write commits the previously buffered write to the array on the same edge, if the buffer holds one. A read of the buffered address returns the buffered lanes merged with the array's other lanes. This includes a read on the edge that delivers the data.
- R6: A cycle with `sel_n`=1 is a deselect. It reads and writes nothing, and its output slot has `dout_en` low.
- R7: With any mode pin pair other than `mode_a`=0 and `mode_b`=0 (the registered pair is `mode_a`=0, `mode_b`=1), data for a read at edge n is driven from edge n+1 until edge n+2.
- R8: With `mode_a`=0 and `mode_b`=0 (flow-through), data for a read at edge n is driven from edge n until edge n+1.
- R9: A write, whether full, partial or aborted, gives its output slot `dout_en` low. In flow-through mode the output turns off right after the write's edge.
- R10: While `oe_n` is 1, `dout_en` is low and `dout` is zero. Whenever `dout_en` is low, `dout` is zero.
- R11: While `sleep` is 1, `dout_en` is low whatever the other inputs are.
- R12: The mode pins are static outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_a | input | 1 | Static output-style pin, first of the pair |
| mode_b | input | 1 | Static output-style pin, second of the pair |
| sel_n | input | 1 | Synchronous select, active low |
| wr_n | input | 1 | Global write enable, active low |
| be_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, presented one cycle after its write |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous output shut-off |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | High while `dout` carries valid read data |

## Verification
Each mode is swept over every address of a 16-word memory in several passes:
- Reads before any write show that reset clears the array.
- Back-to-back writes of an address-derived pattern tell the commit-with-arriving-data path (AWAIT→AWAIT) apart from the held path.
- Single-lane, aborted and read-right-after-write cycles separate the lane masking from the forwarding merge.
- A long random mix of reads, writes, aborts and deselects is compared against a reference array with a shadow buffer.
- The output enable and sleep inputs are toggled in the middle of a valid output slot.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic [1:0] {
        BUF_EMPTY = 2'd0,
        BUF_AWAIT = 2'd1,
        BUF_HELD  = 2'd2
    } wbuf_state_t;

    // Flow-through is the only pair with both pins low; all others register.
    function automatic logic is_registered(input logic ma, input logic mb);
        return ma | mb;
    endfunction

endpackage

// File: rtl/lw_wbuf.sv
module lw_wbuf
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DW    = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LANES-1:0]  acc_mask,
    input  logic [DW-1:0]     din,
    output wbuf_state_t       st,
    output logic              cm_en,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [LANES-1:0]  cm_mask,
    output logic [DW-1:0]     cm_data,
    output logic              fw_vld,
    output logic [ADDR_W-1:0] fw_addr,
    output logic [LANES-1:0]  fw_mask,
    output logic [DW-1:0]     fw_data
);

    wbuf_state_t       st_nx;
    logic [ADDR_W-1:0] b_addr;
    logic [LANES-1:0]  b_mask;
    logic [DW-1:0]     b_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BUF_EMPTY;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        unique case (st)
            BUF_EMPTY: st_nx = wr_acc ? BUF_AWAIT : BUF_EMPTY;
            BUF_AWAIT: st_nx = wr_acc ? BUF_AWAIT : BUF_HELD;
            BUF_HELD:  st_nx = wr_acc ? BUF_AWAIT : BUF_HELD;
            default:   st_nx = BUF_EMPTY;
        endcase
    end

    // buffer contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_addr <= '0;
            b_mask <= '0;
            b_data <= '0;
        end else begin
            if (wr_acc) begin
                b_addr <= acc_addr;
                b_mask <= acc_mask;
            end
            if (st == BUF_AWAIT) b_data <= din;
        end
    end

    // outputs: commit port and forwarding view
    always_comb begin
        cm_en   = wr_acc && (st != BUF_EMPTY);
        cm_addr = b_addr;
        cm_mask = b_mask;
        cm_data = (st == BUF_AWAIT) ? din : b_data;
        fw_vld  = (st == BUF_HELD);
        fw_addr = b_addr;
        fw_mask = b_mask;
        fw_data = b_data;
    end

endmodule

// File: rtl/lw_array.sv
module lw_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [LANES-1:0]             wmask,
    input  logic [LANES-1:0][LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]            raddr,
    output logic [LANES-1:0][LANE_W-1:0] rdata
);

    logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int l = 0; l < LANES; l++)
                if (wmask[l]) mem[waddr][l] <= wdata[l];
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/lw_outpath.sv
module lw_outpath #(
    parameter int ADDR_W = 6,
    parameter int DW     = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_mode,
    input  logic              rd_acc,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     flow_val,
    output logic [ADDR_W-1:0] rd_addr_q,
    output logic              slot_vld,
    output logic [DW-1:0]     slot_data
);

    logic          rd_vld_q;
    logic          reg_vld;
    logic [DW-1:0] reg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_addr_q <= '0;
            reg_vld   <= 1'b0;
            reg_q     <= '0;
        end else begin
            rd_vld_q  <= rd_acc;
            if (rd_acc) rd_addr_q <= rd_addr;
            reg_vld   <= rd_vld_q;
            reg_q     <= flow_val;
        end
    end

    always_comb begin
        slot_vld  = reg_mode ? reg_vld : rd_vld_q;
        slot_data = reg_mode ? reg_q   : flow_val;
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DW    = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_a,
    input  logic              mode_b,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     din,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DW-1:0]     dout,
    output logic              dout_en
);

    logic rd_acc, wr_acc, reg_mode;
    assign rd_acc   = !sel_n && wr_n;
    assign wr_acc   = !sel_n && !wr_n;
    assign reg_mode = is_registered(mode_a, mode_b);

    wbuf_state_t       buf_st;
    logic              cm_en, fw_vld;
    logic [ADDR_W-1:0] cm_addr, fw_addr, rd_addr_q;
    logic [LANES-1:0]  cm_mask, fw_mask;
    logic [DW-1:0]     cm_data, fw_data, arr_q, flow_val, slot_data;
    logic              slot_vld;

    lw_wbuf #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .acc_addr(addr),
        .acc_mask(~be_n), .din(din), .st(buf_st),
        .cm_en(cm_en), .cm_addr(cm_addr), .cm_mask(cm_mask), .cm_data(cm_data),
        .fw_vld(fw_vld), .fw_addr(fw_addr), .fw_mask(fw_mask), .fw_data(fw_data)
    );

    lw_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk(clk), .rst_n(rst_n), .we(cm_en), .waddr(cm_addr), .wmask(cm_mask),
        .wdata(cm_data), .raddr(rd_addr_q), .rdata(arr_q)
    );

    // forwarding merge, one mux per lane
    logic fw_hit;
    assign fw_hit = fw_vld && (fw_addr == rd_addr_q);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign flow_val[l*LANE_W +: LANE_W] = (fw_hit && fw_mask[l])
            ? fw_data[l*LANE_W +: LANE_W] : arr_q[l*LANE_W +: LANE_W];
    end

    lw_outpath #(.ADDR_W(ADDR_W), .DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode), .rd_acc(rd_acc),
        .rd_addr(addr), .flow_val(flow_val), .rd_addr_q(rd_addr_q),
        .slot_vld(slot_vld), .slot_data(slot_data)
    );

    // asynchronous output gating
    always_comb begin
        dout_en = slot_vld && !oe_n && !sleep;
        dout    = dout_en ? slot_data : '0;
    end

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
    import lw_sram_pkg::*;
#(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_a,
    input logic          mode_b,
    input logic          sel_n,
    input logic          wr_n,
    input logic          oe_n,
    input logic          sleep,
    input logic          dout_en,
    input logic [DW-1:0] dout,
    input wbuf_state_t   buf_st
);

    assert_sleep_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_en);

    assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    assert_flow_write_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_a && !mode_b && !sel_n && !wr_n) |=> !dout_en);

    assert_reg_write_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_a || mode_b) && !sel_n && !wr_n) |=> ##1 !dout_en);

    assert_flow_desel_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_a && !mode_b && sel_n) |=> !dout_en);

    assert_late_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |=> (buf_st == BUF_AWAIT));

    assert_buffer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_st == BUF_AWAIT && sel_n) |=> (buf_st == BUF_HELD));

    assert_mode_static_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_a) && $stable(mode_b));

endmodule

bind lw_sram lw_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
    .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n), .sleep(sleep),
    .dout_en(dout_en), .dout(dout), .buf_st(buf_st)
);

// File: tb/lw_sram_bench.sv
`timescale 1ns/1ps
module lw_sram_bench;

    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_a = 1'b0, mode_b = 1'b0;
    logic        sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [1:0]  be_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        dout_en;

    always #2.5 clk = ~clk;

    lw_sram #(.ADDR_W(AW)) u_lw_sram (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .sel_n(sel_n), .wr_n(wr_n), .be_n(be_n), .addr(addr), .din(din),
        .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
    );

    int nchk = 0, nfail = 0;
    logic done = 1'b0;

    // reference model
    logic [17:0]   ref_mem [N];
    logic          bvalid, pend, regm, rv_vld;
    logic [AW-1:0] baddr;
    logic [1:0]    bmask;
    logic [17:0]   bdata, rv_val;
    logic          exp_en_l;
    logic [17:0]   exp_d_l;

    function automatic logic [17:0] pat(input int a, input int salt);
        return 18'((a * 18'h0A5) ^ 18'h2C3A1 ^ (salt * 18'h1357));
    endfunction

    function automatic logic [17:0] merged(input logic [AW-1:0] a);
        logic [17:0] v;
        v = ref_mem[a];
        if (bvalid && !pend && baddr == a) begin
            if (bmask[0]) v[8:0]  = bdata[8:0];
            if (bmask[1]) v[17:9] = bdata[17:9];
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic ee, input logic [17:0] ed);
        nchk++;
        if (dout_en !== ee || dout !== ed) begin
            nfail++;
            $display("FAIL %s: got en=%0b dout=%05h, expected en=%0b dout=%05h",
                     tag, dout_en, dout, ee, ed);
        end
    endtask

    task automatic do_reset(input logic ma, input logic mb);
        rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; be_n = 2'b11;
        oe_n = 1'b0; sleep = 1'b0;
        mode_a = ma; mode_b = mb; regm = ma | mb;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < N; i++) ref_mem[i] = '0;
        bvalid = 0; pend = 0; rv_vld = 0; rv_val = '0; baddr = '0;
        bmask = '0; bdata = '0;
        check("R1 reset output off", 1'b0, 18'h0);
    endtask

    // one clock: drive, wait edge, update model, check output
    task automatic step(input logic s_n, input logic w_n, input logic [1:0] ben,
                        input logic [AW-1:0] a, input logic [17:0] d, input string tag);
        logic rd;
        logic [17:0] rv;
        logic ee;
        logic [17:0] ed;
        sel_n = s_n; wr_n = w_n; be_n = ben; addr = a; din = d;
        @(posedge clk); #1;
        rd = !s_n && w_n;
        rv = '0;
        if (pend) begin bdata = d; pend = 0; end
        if (!s_n && !w_n) begin
            if (bvalid) begin
                if (bmask[0]) ref_mem[baddr][8:0]  = bdata[8:0];
                if (bmask[1]) ref_mem[baddr][17:9] = bdata[17:9];
            end
            baddr = a; bmask = ~ben; pend = 1; bvalid = 1;
        end
        if (rd) rv = merged(a);
        if (!regm) begin
            ee = rd; ed = rd ? rv : '0;
        end else begin
            ee = rv_vld; ed = rv_vld ? rv_val : '0;
            rv_vld = rd; rv_val = rv;
        end
        exp_en_l = ee; exp_d_l = ed;
        check(tag, ee, ed);
    endtask

    // asynchronous gating inside a valid slot
    task automatic gate_test();
        oe_n = 1'b1; #0.5;
        check("R10 oe_n high turns output off", 1'b0, 18'h0);
        oe_n = 1'b0; #0.5;
        check("R10 oe_n low restores output", exp_en_l, exp_d_l);
        sleep = 1'b1; #0.5;
        check("R11 sleep turns output off", 1'b0, 18'h0);
        sleep = 1'b0; #0.5;
        check("R11 sleep release restores output", exp_en_l, exp_d_l);
    endtask

    task automatic run_mode(input logic ma, input logic mb, input int salt);
        string rtag;
        rtag = (ma | mb) ? "R7 registered read" : "R8 flow read";
        do_reset(ma, mb);
        // R1: cleared array
        for (int a = 0; a < N; a++) step(0, 1, 2'b00, AW'(a), '0, "R1 array zero after reset");
        // R3/R5: back-to-back writes, data one cycle late
        step(0, 0, 2'b00, AW'(0), '0, "R9 write slot off");
        for (int a = 1; a < N; a++)
            step(0, 0, 2'b00, AW'(a), pat(a - 1, salt), "R3 R5 back-to-back write");
        step(1, 1, 2'b11, '0, pat(N - 1, salt), "R6 deselect off");
        for (int a = 0; a < N; a++) step(0, 1, 2'b11, AW'(a), '0, rtag);
        step(1, 1, 2'b11, '0, '0, "R6 deselect off");
        // R4: lane 0 only, then abort, then reads
        step(0, 0, 2'b10, AW'(3), '0, "R4 lane write slot off");
        step(1, 1, 2'b11, '0, 18'h3FFFF, "R6 deselect data phase");
        step(0, 1, 2'b11, AW'(3), '0, "R5 forward lane merge");
        step(0, 0, 2'b11, AW'(4), '0, "R4 abort write slot off");
        step(1, 1, 2'b11, '0, 18'h15555, "R4 abort data phase");
        step(0, 1, 2'b11, AW'(4), '0, "R4 abort leaves word");
        step(0, 1, 2'b11, AW'(3), '0, "R4 lane1 untouched");
        step(0, 0, 2'b01, AW'(6), '0, "R4 lane1 write");
        step(1, 1, 2'b11, '0, 18'h2AAAA, "R6 deselect data phase");
        step(0, 1, 2'b11, AW'(6), '0, "R4 R5 lane1 merge");
        // R5: read on the data edge of a write to the same address
        step(0, 0, 2'b00, AW'(5), '0, "R9 write slot off");
        step(0, 1, 2'b11, AW'(5), 18'h0BEEF, "R5 read on data edge");
        step(1, 1, 2'b11, '0, '0, "R6 deselect off");
        if (!regm) gate_test();
        step(1, 1, 2'b11, '0, '0, "R6 deselect off");
        if (regm) begin
            step(0, 1, 2'b11, AW'(5), '0, "R7 read issue");
            step(1, 1, 2'b11, '0, '0, "R7 registered read");
            gate_test();
        end else begin
            step(0, 1, 2'b11, AW'(5), '0, "R8 flow read");
            gate_test();
        end
        // random mix
        for (int k = 0; k < 600; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4)
                step(0, 1, 2'($urandom_range(0, 3)), AW'($urandom_range(0, N - 1)),
                     18'($urandom), "R2 R5 mix read");
            else if (op < 8)
                step(0, 0, 2'($urandom_range(0, 3)), AW'($urandom_range(0, N - 1)),
                     18'($urandom), "R3 R4 R9 mix write");
            else
                step(1, 2'($urandom_range(0, 1)) != 0, 2'b00, AW'($urandom_range(0, N - 1)),
                     18'($urandom), "R6 mix deselect");
        end
        // final readback of the whole array
        step(1, 1, 2'b11, '0, 18'($urandom), "R6 deselect");
        for (int a = 0; a < N; a++) step(0, 1, 2'b11, AW'(a), '0, "R2 final readback");
        step(1, 1, 2'b11, '0, '0, "R6 drain");
    endtask

    initial begin
        #1;
        run_mode(1'b0, 1'b0, 1);   // flow-through
        run_mode(1'b0, 1'b1, 2);   // registered
        run_mode(1'b1, 1'b0, 3);   // other pair also registered (R7)
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule